// File: doc/BRIEF.md
# Pixel Contrast Expansion Stage

This block stretches a chosen window of a 12-bit pixel stream across the full output range. A signed offset moves the window, and a fixed-point gain then scales it. The gain is one plus the gain code in eighths. The result is clamped to the representable range and leaves the block two clock cycles after the pixel enters, together with a delayed valid flag.

The settings are gain code, offset code and a two-bit mode field. They are sampled only in the cycle that carries the frame-start marker, so every pixel of a frame uses one set of settings. Pixels flagged as test-pattern data pass through without change, whatever the mode. The mode field can enable the offset alone, the gain alone, both, or neither.

Top module: `gain_offset_stage`

## Requirements
- R1: While rst_ni is low, pix_valid_o and pix_o are 0.
- R2: pix_valid_o equals pix_valid_i delayed by exactly two clock cycles. The pixel result for an input sampled at edge k appears on pix_o after edge k+1.
- R3: With mode 2'b11, pix_o = floor((pix + ofs) × (8 + gain_code) / 8). Here ofs is offset_code_i read as a 13-bit two's-complement value (−4096..+4095).
- R4: Gain code 0 gives ×1 and gain code 255 gives ×32.875 (multiplier 263/8).
- R5: A negative value of pix + ofs yields pix_o = 0.
- R6: A scaled result above 4095 yields pix_o = 4095.
- R7: With mode 2'b00, pix_o equals the input pixel.
- R8: With mode 2'b01, only the offset is applied, with clamping to 0..4095 and a gain of ×1.
- R9: With mode 2'b10, only the gain is applied, with an offset of 0, and the result saturates at 4095.
- R10: A pixel with test_pat_i high is output unchanged in every mode.
- R11: Gain, offset and mode are taken from the inputs in a cycle with sof_i high. They apply to that cycle's pixel and to every pixel until the next sof_i. Changes to these inputs in other cycles have no effect on pix_o.
- R12: After reset and before the first sof_i, the stage uses gain code 0, offset 0 and mode 2'b11, so pix_o equals the input pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 12 | Input pixel |
| pix_valid_i | input | 1 | Input pixel valid |
| test_pat_i | input | 1 | Pixel is test-pattern data; bypass processing |
| sof_i | input | 1 | Frame start; samples the settings |
| gain_code_i | input | 8 | Gain code, gain = 1 + code/8 |
| offset_code_i | input | 13 | Offset, two's complement |
| proc_ctrl_i | input | 2 | Mode: bit 0 enables the offset, bit 1 enables the gain |
| pix_o | output | 12 | Processed, saturated pixel |
| pix_valid_o | output | 1 | Output valid |

## Verification
The bench builds the block with its default parameters: 12-bit pixels, an 8-bit gain code with 3 fractional bits, and a 13-bit offset. These give an intermediate sum of up to 8190 and a multiplier of up to 263. Full-range random codes and pixels therefore reach both clamps often: the negative clamp through large negative offsets, and saturation through any gain above about ×2 on mid-range pixels. Frames that change the settings between frame starts exercise the sampling rule against a bench model that latches only at frame start.

// File: rtl/gain_offset_pkg.sv
package gain_offset_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'b00,
    MODE_OFS  = 2'b01,
    MODE_GAIN = 2'b10,
    MODE_FULL = 2'b11
  } proc_mode_e;
endpackage

// File: rtl/gos_cfg_latch.sv
module gos_cfg_latch #(
  parameter int GAIN_W = 8,
  parameter int OFS_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [1:0]        mode_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [1:0]        mode_o
);
  import gain_offset_pkg::*;

  logic [GAIN_W-1:0] gain_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [1:0]        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '0;
      ofs_q  <= '0;
      mode_q <= MODE_FULL;
    end else if (sof_i) begin
      gain_q <= gain_i;
      ofs_q  <= ofs_i;
      mode_q <= mode_i;
    end
  end

  // frame-start pixel already uses the new settings
  assign gain_o = sof_i ? gain_i : gain_q;
  assign ofs_o  = sof_i ? ofs_i  : ofs_q;
  assign mode_o = sof_i ? mode_i : mode_q;

  // R11
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> ($stable(gain_q) && $stable(ofs_q) && $stable(mode_q)));
endmodule

// File: rtl/gos_offset_stage.sv
module gos_offset_stage #(
  parameter int PIX_W  = 12,
  parameter int GAIN_W = 8,
  parameter int FRAC_W = 3,
  parameter int OFS_W  = 13,
  localparam int SUM_W  = (PIX_W + 2 > OFS_W + 1) ? PIX_W + 2 : OFS_W + 1,
  localparam int MULT_W = GAIN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              test_pat_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [1:0]        mode_i,
  output logic              vld_o,
  output logic [SUM_W-2:0]  sum_o,
  output logic [MULT_W-1:0] mult_o
);
  localparam logic [MULT_W-1:0] UNITY = MULT_W'(1) << FRAC_W;

  logic              ofs_en, gain_en;
  logic [SUM_W-1:0]  pix_ext, ofs_ext, sum_s;
  logic [SUM_W-2:0]  sum_d;
  logic [MULT_W-1:0] mult_d;

  always_comb begin
    ofs_en  = mode_i[0] & ~test_pat_i;
    gain_en = mode_i[1] & ~test_pat_i;
    pix_ext = {{(SUM_W-PIX_W){1'b0}}, pix_i};
    ofs_ext = ofs_en ? {{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i} : '0;
    sum_s   = pix_ext + ofs_ext;
    sum_d   = sum_s[SUM_W-1] ? '0 : sum_s[SUM_W-2:0];
    mult_d  = gain_en ? UNITY + {1'b0, gain_i} : UNITY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      sum_o  <= '0;
      mult_o <= UNITY;
    end else begin
      vld_o  <= vld_i;
      sum_o  <= sum_d;
      mult_o <= mult_d;
    end
  end

  // R7
  ofs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (test_pat_i || !mode_i[0])) |=> sum_o == (SUM_W-1)'($past(pix_i)));
endmodule

// File: rtl/gos_gain_stage.sv
module gos_gain_stage #(
  parameter int PIX_W  = 12,
  parameter int FRAC_W = 3,
  parameter int SUMQ_W = 13,
  parameter int MULT_W = 9,
  localparam int PROD_W = SUMQ_W + MULT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [SUMQ_W-1:0] sum_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic              vld_o,
  output logic [PIX_W-1:0]  pix_o
);
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic [PROD_W-1:0]        prod;
  logic [PROD_W-FRAC_W-1:0] scaled;
  logic [PIX_W-1:0]         pix_d;

  always_comb begin
    prod   = PROD_W'(sum_i) * PROD_W'(mult_i);
    scaled = prod[PROD_W-1:FRAC_W];
    pix_d  = (|scaled[PROD_W-FRAC_W-1:PIX_W]) ? PIX_MAX : scaled[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      pix_o <= '0;
    end else begin
      vld_o <= vld_i;
      pix_o <= pix_d;
    end
  end

  // R6
  sat_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && sum_i >= SUMQ_W'(PIX_MAX)) |=> pix_o == PIX_MAX);
endmodule

// File: rtl/gain_offset_stage.sv
module gain_offset_stage #(
  parameter int PIX_W  = 12,
  parameter int GAIN_W = 8,
  parameter int FRAC_W = 3,
  parameter int OFS_W  = 13,
  localparam int SUM_W  = (PIX_W + 2 > OFS_W + 1) ? PIX_W + 2 : OFS_W + 1,
  localparam int MULT_W = GAIN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              pix_valid_i,
  input  logic              test_pat_i,
  input  logic              sof_i,
  input  logic [GAIN_W-1:0] gain_code_i,
  input  logic [OFS_W-1:0]  offset_code_i,
  input  logic [1:0]        proc_ctrl_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              pix_valid_o
);
  logic [GAIN_W-1:0] gain_eff;
  logic [OFS_W-1:0]  ofs_eff;
  logic [1:0]        mode_eff;
  logic              s1_vld;
  logic [SUM_W-2:0]  s1_sum;
  logic [MULT_W-1:0] s1_mult;

  gos_cfg_latch #(.GAIN_W(GAIN_W), .OFS_W(OFS_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sof_i  (sof_i),
    .gain_i (gain_code_i),
    .ofs_i  (offset_code_i),
    .mode_i (proc_ctrl_i),
    .gain_o (gain_eff),
    .ofs_o  (ofs_eff),
    .mode_o (mode_eff)
  );

  gos_offset_stage #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W)) u_ofs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (pix_valid_i),
    .pix_i      (pix_i),
    .test_pat_i (test_pat_i),
    .gain_i     (gain_eff),
    .ofs_i      (ofs_eff),
    .mode_i     (mode_eff),
    .vld_o      (s1_vld),
    .sum_o      (s1_sum),
    .mult_o     (s1_mult)
  );

  gos_gain_stage #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .SUMQ_W(SUM_W-1), .MULT_W(MULT_W)) u_gain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (s1_vld),
    .sum_i  (s1_sum),
    .mult_i (s1_mult),
    .vld_o  (pix_valid_o),
    .pix_o  (pix_o)
  );

  // cycles since reset, for two-deep history checks only
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= '0;
    else         warm_q <= {warm_q[0], 1'b1};
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q[1] |-> pix_valid_o == $past(pix_valid_i, 2));

  // R10
  tp_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q[1] && $past(pix_valid_i && test_pat_i, 2)) |-> pix_o == $past(pix_i, 2));
endmodule

// File: tb/gain_offset_stage_bench.sv
module gain_offset_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 4095;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pix_i = '0;
  logic        vld_i = 1'b0, tp_i = 1'b0, sof_i = 1'b0;
  logic [7:0]  gain_i = '0;
  logic [12:0] ofs_i = '0;
  logic [1:0]  mode_i = '0;
  logic [11:0] pix_o;
  logic        vld_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench-side latched settings
  logic [7:0]  m_gain = '0;
  logic [12:0] m_ofs = '0;
  logic [1:0]  m_mode = 2'b11;
  string tag_ovr = "";

  bit    pv0 = 0, pv1 = 0;
  int    pd0 = 0, pd1 = 0;
  string pt0 = "R2", pt1 = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_offset_stage u_gain_offset_stage (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix_i), .pix_valid_i(vld_i),
    .test_pat_i(tp_i), .sof_i(sof_i), .gain_code_i(gain_i),
    .offset_code_i(ofs_i), .proc_ctrl_i(mode_i),
    .pix_o(pix_o), .pix_valid_o(vld_o)
  );

  function automatic int model(input int p, input bit tp, input int g,
                               input logic [12:0] o, input logic [1:0] m,
                               output string tag);
    int s, r;
    if (tp) begin tag = "R10"; return p; end
    if (m == 2'b00) begin tag = "R7"; return p; end
    s = p + (m[0] ? int'($signed(o)) : 0);
    if (s < 0) s = 0;
    r = (s * (m[1] ? 8 + g : 8)) / 8;
    if (r > MAXV) r = MAXV;
    if (m == 2'b01) tag = "R8";
    else if (m == 2'b10) tag = "R9";
    else if (p + int'($signed(o)) < 0) tag = "R5";
    else if ((s * (8 + g)) / 8 > MAXV) tag = "R6";
    else if (g == 0 || g == 255) tag = "R4";
    else tag = "R3";
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input int p, input bit tp, input bit sof,
                      input int g, input int o, input int m);
    string t;
    int e;
    @(negedge clk);
    check("R2", int'(vld_o), int'(pv1));
    if (pv1) check(pt1, int'(pix_o), pd1);
    pv1 = pv0; pd1 = pd0; pt1 = pt0;
    vld_i = v; pix_i = 12'(p); tp_i = tp; sof_i = sof;
    gain_i = 8'(g); ofs_i = 13'(o); mode_i = 2'(m);
    if (sof) begin m_gain = 8'(g); m_ofs = 13'(o); m_mode = 2'(m); end
    e = model(p, tp, int'(m_gain), m_ofs, m_mode, t);
    pv0 = v; pd0 = e; pt0 = (tag_ovr != "") ? tag_ovr : t;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int r;
    r = $urandom(32'h5eed_0bad);
    vld_i = 1'b1; pix_i = 12'd777;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(vld_o), 0);
    check("R1", int'(pix_o), 0);
    rst_n = 1'b1;
    vld_i = 1'b0;

    // R12: defaults before any frame start, inputs ignored without sof
    tag_ovr = "R12";
    step(1, 1234, 0, 0, 200, 4000, 3);
    step(1, 4095, 0, 0, 255, -4096, 1);
    step(1, 0, 0, 0, 17, 99, 2);
    flush();
    tag_ovr = "";

    // directed corners
    step(1, 100, 0, 1, 255, 0, 3);        // R4: 100*263/8 = 3287
    step(1, 99, 0, 0, 0, 0, 0);
    step(1, 10, 0, 1, 0, -100, 3);        // R5
    step(1, 4000, 0, 1, 0, 4095, 3);      // R6
    step(1, 4095, 0, 1, 255, 0, 2);       // R9 saturate
    step(1, 50, 0, 1, 40, -60, 1);        // R8 clamp low
    step(1, 3000, 1, 1, 255, 4095, 3);    // R10
    step(1, 321, 0, 1, 255, 4095, 0);     // R7
    step(1, 1000, 0, 1, 8, 24, 3);        // R3: 1024*16/8 = 2048
    step(1, 4095, 0, 1, 0, 0, 3);         // R4 unity
    flush();

    // R11: settings change mid-frame without sof
    step(1, 500, 0, 1, 8, 0, 3);
    tag_ovr = "R11";
    step(1, 500, 0, 0, 255, -4096, 0);
    step(1, 600, 0, 0, 0, 4095, 1);
    step(0, 700, 0, 0, 100, 100, 2);
    step(1, 700, 0, 0, 100, 100, 2);
    tag_ovr = "";
    flush();

    // constrained random frames
    for (int f = 0; f < 60; f++) begin
      int len;
      len = 20 + int'($urandom_range(80));
      for (int i = 0; i < len; i++) begin
        bit sof;
        sof = (i == 0);
        step(($urandom_range(9) != 0), int'($urandom_range(4095)),
             ($urandom_range(15) == 0), sof,
             int'($urandom_range(255)), int'($urandom_range(8191)),
             int'($urandom_range(3)));
      end
    end
    flush();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule